// File: doc/BRIEF.md
# Inter-Processor Doorbell Register

This block is a 32-bit doorbell register that sits between two processors, called the host and the coprocessor. Each processor has its own write port and its own read port. To interrupt the other side, a processor writes a 1 into one of the "ring" bits it owns. That bit is never stored, so it always reads back as 0. The write does two things: it sends a one-cycle interrupt pulse toward the receiver, and it latches a "pending" flag in the same register.

The receiver writes a 0 to that pending flag once it has serviced the interrupt. The sender can read the pending flag to learn when servicing is done.

Each pending flag sits 16 positions above its ring bit. The host rings four ordinary coprocessor lines and one non-maskable coprocessor line. The coprocessor rings two host lines. Reads on either port are registered and take one cycle.

Top module: `ipi_doorbell`

## Requirements
- R1: After a synchronous reset, every pending flag is 0, all interrupt outputs are low, and both read ports return 0.
- R2: A host write with bit 0 = 1 pulses `cop_nmi` high for exactly the one cycle after the write edge. It also sets pending flag bit 16.
- R3: A host write with bit 4+n = 1 (n = 0..3) pulses `cop_irq[n]` for one cycle after the write edge. It also sets pending flag bit 20+n.
- R4: A coprocessor write with bit 12+n = 1 (n = 0..1) pulses `host_irq[n]` for one cycle after the write edge. It also sets pending flag bit 28+n.
- R5: Ring bits (13:12, 7:4, 0) always read as 0. Reserved bits (31:30, 27:24, 19:17, 15:14, 11:8, 3:1) read as 0, and writes to them have no effect.
- R6: Writing 0 to a ring bit raises nothing. Writing 1 to a pending flag leaves it unchanged.
- R7: The receiver clears its own pending flags by writing 0 to them. The host clears bits 29:28, and the coprocessor clears bits 23:20 and 16. A port writing to ring bits or pending flags it does not own changes nothing.
- R8: When a ring and a clear of the same pending flag arrive in the same cycle, the ring wins and the flag ends up 1.
- R9: When both ports write in the same cycle, both writes take effect on the fields each port owns.
- R10: Read data is captured at the edge where the read enable is high. It shows the register value from before any write at that same edge. It holds its value while the read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_data | input | 32 | Host write data |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_data | output | 32 | Host read data, one cycle after the strobe |
| cop_wr_en | input | 1 | Coprocessor write strobe |
| cop_wr_data | input | 32 | Coprocessor write data |
| cop_rd_en | input | 1 | Coprocessor read strobe |
| cop_rd_data | output | 32 | Coprocessor read data, one cycle after the strobe |
| cop_irq | output | 4 | Interrupt pulses toward the coprocessor |
| cop_nmi | output | 1 | Non-maskable interrupt pulse toward the coprocessor |
| host_irq | output | 2 | Interrupt pulses toward the host |

## Verification
Suppose a pending flag is latched wrongly, or decoded from the wrong port. The error shows on the next read of either port, one cycle after the read strobe, because both ports see the same flags. A wrong ring decode shows sooner: the interrupt output pulses, or fails to pulse, in the cycle right after the write edge. The bench checks that cycle directly. It also checks the cycle after, to confirm the pulse lasts only one cycle. Simultaneous ring-and-clear writes from the two ports catch a wrong priority inside the flag cell.

// File: rtl/ipi_doorbell_pkg.sv
package ipi_doorbell_pkg;

    localparam int REG_W     = 32;
    localparam int STAT_OFS  = 16;
    localparam int NMI_POS   = 0;
    localparam int COP_LINES = 4;
    localparam int COP_LSB   = 4;
    localparam int HST_LINES = 2;
    localparam int HST_LSB   = 12;
    localparam int N_LINES   = 1 + COP_LINES + HST_LINES;

    typedef enum logic {
        SIDE_HOST = 1'b0,
        SIDE_COP  = 1'b1
    } side_e;

    typedef struct packed {
        logic             en;
        logic [REG_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic [N_LINES-1:0] ring;
        logic [N_LINES-1:0] clear;
    } line_ctl_t;

    // Line index 0 is the NMI, 1..COP_LINES are coprocessor lines,
    // the rest are host lines.
    function automatic int ring_pos(input int idx);
        if (idx == 0)
            return NMI_POS;
        else if (idx <= COP_LINES)
            return COP_LSB + idx - 1;
        else
            return HST_LSB + idx - 1 - COP_LINES;
    endfunction

    function automatic side_e sender_of(input int idx);
        return (idx <= COP_LINES) ? SIDE_HOST : SIDE_COP;
    endfunction

    function automatic logic [REG_W-1:0] pend_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < N_LINES; i++)
            m[ring_pos(i) + STAT_OFS] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ipi_write_decode.sv
module ipi_write_decode
    import ipi_doorbell_pkg::*;
(
    input  wr_req_t   host_req,
    input  wr_req_t   cop_req,
    output line_ctl_t ctl
);

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        localparam int    RPOS = ring_pos(i);
        localparam int    PPOS = RPOS + STAT_OFS;
        localparam side_e SND  = sender_of(i);

        if (SND == SIDE_HOST) begin : g_host_sends
            assign ctl.ring[i]  = host_req.en & host_req.data[RPOS];
            assign ctl.clear[i] = cop_req.en & ~cop_req.data[PPOS];
        end else begin : g_cop_sends
            assign ctl.ring[i]  = cop_req.en & cop_req.data[RPOS];
            assign ctl.clear[i] = host_req.en & ~host_req.data[PPOS];
        end
    end

endmodule

// File: rtl/ipi_line.sv
module ipi_line (
    input  logic clk,
    input  logic rst,
    input  logic ring,
    input  logic clear,
    output logic pending,
    output logic pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            pulse   <= 1'b0;
        end else begin
            pulse <= ring;
            if (ring)
                pending <= 1'b1;
            else if (clear)
                pending <= 1'b0;
        end
    end

    // R8: a ring always leaves the flag set, even against a clear
    a_r8_ring_wins: assert property (@(posedge clk) disable iff (rst)
        ring |=> pending);

    // R7: a clear with no ring drops the flag
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clear && !ring) |=> !pending);

    // R6: without ring or clear the flag holds
    a_r6_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (!ring && !clear) |=> $stable(pending));

    // R2: a flag only rises together with its interrupt pulse
    a_r2_rise_with_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> pulse);

endmodule

// File: rtl/ipi_read_port.sv
module ipi_read_port
    import ipi_doorbell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [REG_W-1:0] value,
    output logic [REG_W-1:0] rd_data
);

    localparam logic [REG_W-1:0] PMASK = pend_mask();

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= value & PMASK;
    end

    // R10: read data holds while the strobe is low
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R5: reserved and ring positions never read as 1
    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~PMASK) == '0);

endmodule

// File: rtl/ipi_doorbell.sv
module ipi_doorbell
    import ipi_doorbell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr_en,
    input  logic [REG_W-1:0] host_wr_data,
    input  logic             host_rd_en,
    output logic [REG_W-1:0] host_rd_data,
    input  logic             cop_wr_en,
    input  logic [REG_W-1:0] cop_wr_data,
    input  logic             cop_rd_en,
    output logic [REG_W-1:0] cop_rd_data,
    output logic [COP_LINES-1:0] cop_irq,
    output logic             cop_nmi,
    output logic [HST_LINES-1:0] host_irq
);

    wr_req_t            host_req;
    wr_req_t            cop_req;
    line_ctl_t          ctl;
    logic [N_LINES-1:0] pend;
    logic [N_LINES-1:0] pulse;
    logic [REG_W-1:0]   reg_value;

    assign host_req = '{en: host_wr_en, data: host_wr_data};
    assign cop_req  = '{en: cop_wr_en,  data: cop_wr_data};

    ipi_write_decode u_dec (
        .host_req (host_req),
        .cop_req  (cop_req),
        .ctl      (ctl)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_cell
        ipi_line u_line (
            .clk     (clk),
            .rst     (rst),
            .ring    (ctl.ring[i]),
            .clear   (ctl.clear[i]),
            .pending (pend[i]),
            .pulse   (pulse[i])
        );
    end

    always_comb begin
        reg_value = '0;
        for (int i = 0; i < N_LINES; i++)
            reg_value[ring_pos(i) + STAT_OFS] = pend[i];
    end

    assign cop_nmi  = pulse[0];
    assign cop_irq  = pulse[COP_LINES:1];
    assign host_irq = pulse[N_LINES-1:COP_LINES+1];

    ipi_read_port u_host_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (host_rd_en),
        .value   (reg_value),
        .rd_data (host_rd_data)
    );

    ipi_read_port u_cop_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (cop_rd_en),
        .value   (reg_value),
        .rd_data (cop_rd_data)
    );

    // R1: interrupt outputs are low in the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (cop_irq == '0 && !cop_nmi && host_irq == '0));

    // R7: the host never causes an interrupt toward itself
    a_r7_host_no_self: assert property (@(posedge clk) disable iff (rst)
        !$past(cop_wr_en) |-> host_irq == '0);

endmodule

// File: tb/ipi_doorbell_test.sv
`timescale 1ns/1ps
module ipi_doorbell_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic        host_rd_en = 1'b0;
    logic [31:0] host_rd_data;
    logic        cop_wr_en = 1'b0;
    logic [31:0] cop_wr_data = '0;
    logic        cop_rd_en = 1'b0;
    logic [31:0] cop_rd_data;
    logic [3:0]  cop_irq;
    logic        cop_nmi;
    logic [1:0]  host_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    ipi_doorbell uut (
        .clk          (clk),
        .rst          (rst),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .host_rd_en   (host_rd_en),
        .host_rd_data (host_rd_data),
        .cop_wr_en    (cop_wr_en),
        .cop_wr_data  (cop_wr_data),
        .cop_rd_en    (cop_rd_en),
        .cop_rd_data  (cop_rd_data),
        .cop_irq      (cop_irq),
        .cop_nmi      (cop_nmi),
        .host_irq     (host_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Drive one write cycle; returns at the negedge where the pulses are visible.
    task automatic wr(input logic h_en, input logic [31:0] h_d,
                      input logic c_en, input logic [31:0] c_d);
        @(negedge clk);
        host_wr_en = h_en; host_wr_data = h_d;
        cop_wr_en  = c_en; cop_wr_data  = c_d;
        @(negedge clk);
        host_wr_en = 1'b0; cop_wr_en = 1'b0;
    endtask

    task automatic pulses(input string req, input logic [3:0] ci, input logic nmi, input logic [1:0] hi);
        chk({req, " cop_irq"},  {28'd0, cop_irq},  {28'd0, ci});
        chk({req, " cop_nmi"},  {31'd0, cop_nmi},  {31'd0, nmi});
        chk({req, " host_irq"}, {30'd0, host_irq}, {30'd0, hi});
    endtask

    task automatic read_both(input string req, input logic [31:0] exp);
        @(negedge clk);
        host_rd_en = 1'b1; cop_rd_en = 1'b1;
        @(negedge clk);
        host_rd_en = 1'b0; cop_rd_en = 1'b0;
        chk({req, " host read"}, host_rd_data, exp);
        chk({req, " cop read"},  cop_rd_data,  exp);
    endtask

    task automatic t_reset;
        pulses("R1", 4'h0, 1'b0, 2'b00);
        read_both("R1", 32'h0000_0000);
    endtask

    task automatic t_nmi;
        wr(1'b1, 32'h3000_0001, 1'b0, '0);
        pulses("R2 pulse", 4'h0, 1'b1, 2'b00);
        @(negedge clk);
        pulses("R2 one cycle", 4'h0, 1'b0, 2'b00);
        read_both("R2 R5", 32'h0001_0000);
    endtask

    task automatic t_cop_lines;
        for (int i = 0; i < 4; i++) begin
            wr(1'b1, 32'h3000_0000 | (32'h1 << (4 + i)), 1'b0, '0);
            pulses("R3 pulse", 4'h1 << i, 1'b0, 2'b00);
        end
        @(negedge clk);
        pulses("R3 one cycle", 4'h0, 1'b0, 2'b00);
        read_both("R3", 32'h00F1_0000);
    endtask

    task automatic t_cop_clear;
        wr(1'b0, '0, 1'b1, 32'hFFDF_CFFF);
        pulses("R6 zero ring", 4'h0, 1'b0, 2'b00);
        read_both("R7 receiver clear", 32'h00D1_0000);
        wr(1'b1, 32'h3000_0000, 1'b0, '0);
        read_both("R7 non-owner clear", 32'h00D1_0000);
        wr(1'b0, '0, 1'b1, 32'h00F1_0000);
        read_both("R6 write one to flag", 32'h00D1_0000);
    endtask

    task automatic t_host_lines;
        wr(1'b0, '0, 1'b1, 32'h00D1_1000);
        pulses("R4 line0", 4'h0, 1'b0, 2'b01);
        wr(1'b0, '0, 1'b1, 32'h00D1_2000);
        pulses("R4 line1", 4'h0, 1'b0, 2'b10);
        wr(1'b0, '0, 1'b1, 32'h00D1_00F1);
        pulses("R7 non-owner ring", 4'h0, 1'b0, 2'b00);
        read_both("R4", 32'h30D1_0000);
    endtask

    task automatic t_reserved;
        wr(1'b1, 32'hFFFF_FFFF, 1'b0, '0);
        pulses("R5 all ones", 4'hF, 1'b1, 2'b00);
        read_both("R5 reserved", 32'h30F1_0000);
    endtask

    task automatic t_set_wins;
        wr(1'b1, 32'h0000_0010, 1'b1, 32'h00E1_1000);
        pulses("R9 both writes", 4'h1, 1'b0, 2'b01);
        read_both("R8 ring wins", 32'h10F1_0000);
    endtask

    task automatic t_read;
        read_both("R10", 32'h10F1_0000);
        wr(1'b0, '0, 1'b1, 32'h0000_0000);
        chk("R10 hold host", host_rd_data, 32'h10F1_0000);
        chk("R10 hold cop",  cop_rd_data,  32'h10F1_0000);
        read_both("R10 update", 32'h1000_0000);
        @(negedge clk);
        host_rd_en = 1'b1;
        cop_wr_en = 1'b1; cop_wr_data = 32'h0000_2000;
        @(negedge clk);
        host_rd_en = 1'b0; cop_wr_en = 1'b0;
        chk("R10 pre-write value", host_rd_data, 32'h1000_0000);
        pulses("R4 same-edge ring", 4'h0, 1'b0, 2'b10);
        read_both("R10 after write", 32'h3000_0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_nmi();
        t_cop_lines();
        t_cop_clear();
        t_host_lines();
        t_reserved();
        t_set_wins();
        t_read();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule